// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is a sequential integer multiply/divide engine with two 32-bit result registers, HI and LO. A one-cycle start strobe launches one of four operations: signed or unsigned multiply, or signed or unsigned divide. The unit then runs one iteration per clock for 32 clocks and writes both result registers on the last iteration. Multiplication adds the multiplicand into a partial product for every set multiplier bit and shifts right. Division is restoring: it shifts in the next dividend bit, tries to subtract the divisor, and keeps the difference only when it does not go negative.

Signed operations work on operand magnitudes, and the result signs are fixed when the results are written. No overflow or zero-divisor detection exists: every operation finishes in the same number of cycles. A separate output carries the low 32 bits of the most recent product, for a three-operand multiply form that wants only that word.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is asserted and after its release, `hi_o`, `lo_o` and `mul_lo_o` read zero and `busy_o` and `done_o` are low.
- R2: A start while idle raises `busy_o` from the next cycle. `busy_o` stays high for exactly 32 cycles. `done_o` is high for the single cycle right after `busy_o` falls, and `busy_o` is low in that cycle.
- R3: A start seen while `busy_o` is high is ignored. The running operation keeps its timing and its result, and no new operation is queued.
- R4: `op_i` = 2'b01 gives an unsigned multiply: {HI, LO} is the unsigned 64-bit product of `a_i` and `b_i`.
- R5: `op_i` = 2'b00 gives a signed multiply: {HI, LO} is the 64-bit two's-complement product of the two operands.
- R6: `op_i` = 2'b11 gives an unsigned divide with a non-zero divisor. LO is the quotient of `a_i` by `b_i` and HI is the remainder.
- R7: `op_i` = 2'b10 gives a signed divide with a non-zero divisor. The quotient is truncated toward zero and the remainder has the sign of the dividend. The most negative dividend divided by -1 gives LO = 0x80000000 and HI = 0.
- R8: A zero divisor still completes. HI equals `a_i`. LO is 0xFFFFFFFF, except for a signed divide with a negative dividend, which gives LO = 0x00000001.
- R9: HI and LO keep their values at all times except in the cycle where `done_o` rises.
- R10: `mul_lo_o` holds the low 32 bits of the product of the last completed multiply, and a divide leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, accepted only while idle |
| op_i | input | 2 | Operation: 00 mult, 01 multu, 10 div, 11 divu |
| a_i | input | 32 | Multiplier or dividend |
| b_i | input | 32 | Multiplicand or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | HI register: upper product word or remainder |
| lo_o | output | 32 | LO register: lower product word or quotient |
| mul_lo_o | output | 32 | Low product word of the last multiply |

## Verification
The bench targets the signed corners: operands of 0x80000000 in both multiply and divide, mixed-sign operands, and remainders that must follow the dividend's sign. A wrong sign fix would flip a quotient or a remainder, or lose the upper product word. Zero divisors are checked against the all-ones and one quotients, which exposes a design that traps, stalls or clips. Starts are fired in the middle of an operation and in the done cycle. A unit that restarts on a stray start would stretch `busy_o`. One that refuses back-to-back launches would drop a result. Divides between multiplies show whether `mul_lo_o` or HI/LO leak intermediate state.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULT  = 2'b00,
    OP_MULTU = 2'b01,
    OP_DIV   = 2'b10,
    OP_DIVU  = 2'b11
  } op_e;

  function automatic logic op_is_div(op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(op_e op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic launch_o,
  output logic last_o,
  output logic done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic busy_q, done_q;

  assign launch_o = start_i & ~busy_q;
  assign last_o   = busy_q & (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (launch_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  // start pulses during an operation must not rewind the count
  p_count_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         div_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] nxt_hi_o,
  output logic [W-1:0] nxt_lo_o
);
  logic [W-1:0] hi_q, lo_q, opd_q;
  logic         div_q;
  logic [W:0]   sum;
  logic [W:0]   up;
  logic [W-1:0] diff;
  logic         fits;

  // hi_q: partial product / partial remainder; lo_q: multiplier / quotient
  always_comb begin
    sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, opd_q} : '0);
    up   = {hi_q, lo_q[W-1]};
    fits = up >= {1'b0, opd_q};
    diff = up[W-1:0] - opd_q;
    if (div_q) begin
      nxt_hi_o = fits ? diff : up[W-1:0];
      nxt_lo_o = {lo_q[W-2:0], fits};
    end else begin
      nxt_hi_o = sum[W:1];
      nxt_lo_o = {sum[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      opd_q <= '0;
      div_q <= 1'b0;
    end else if (load_i) begin
      hi_q  <= '0;
      lo_q  <= opa_i;
      opd_q <= opb_i;
      div_q <= div_i;
    end else if (step_i) begin
      hi_q  <= nxt_hi_o;
      lo_q  <= nxt_lo_o;
    end
  end

  p_rem_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q && opd_q != '0) |-> (hi_q < opd_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [31:0]  a_i,
  input  logic [31:0]  b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [31:0]  hi_o,
  output logic [31:0]  lo_o,
  output logic [31:0]  mul_lo_o
);
  localparam int W2 = 2 * W;

  op_e          op_in, op_q;
  logic         launch, last, busy;
  logic         a_neg, b_neg, qneg_q, rneg_q;
  logic [W-1:0] a_mag, b_mag, nxt_hi, nxt_lo;
  logic [W2-1:0] prod_f;
  logic [W-1:0] quo_f, rem_f, res_hi, res_lo;
  logic [W-1:0] hi_q, lo_q, mul_lo_q;

  assign op_in = op_e'(op_i);
  assign a_neg = op_is_signed(op_in) & a_i[W-1];
  assign b_neg = op_is_signed(op_in) & b_i[W-1];
  assign a_mag = a_neg ? -a_i : a_i;
  assign b_mag = b_neg ? -b_i : b_i;

  muldiv_seq #(.W(W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy),
    .launch_o (launch),
    .last_o   (last),
    .done_o   (done_o)
  );

  muldiv_step #(.W(W)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (launch),
    .step_i   (busy),
    .div_i    (op_is_div(op_in)),
    .opa_i    (a_mag),
    .opb_i    (b_mag),
    .nxt_hi_o (nxt_hi),
    .nxt_lo_o (nxt_lo)
  );

  // sign fix on the final iteration's value
  always_comb begin
    prod_f = qneg_q ? -{nxt_hi, nxt_lo} : {nxt_hi, nxt_lo};
    quo_f  = qneg_q ? -nxt_lo : nxt_lo;
    rem_f  = rneg_q ? -nxt_hi : nxt_hi;
    res_hi = op_is_div(op_q) ? rem_f : prod_f[W2-1:W];
    res_lo = op_is_div(op_q) ? quo_f : prod_f[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_MULT;
      qneg_q   <= 1'b0;
      rneg_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      mul_lo_q <= '0;
    end else begin
      if (launch) begin
        op_q   <= op_in;
        qneg_q <= a_neg ^ b_neg;
        rneg_q <= a_neg;
      end
      if (last) begin
        hi_q <= res_hi;
        lo_q <= res_lo;
        if (!op_is_div(op_q)) mul_lo_q <= res_lo;
      end
    end
  end

  assign busy_o   = busy;
  assign hi_o     = hi_q;
  assign lo_o     = lo_q;
  assign mul_lo_o = mul_lo_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
  p_mul_lo_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_is_div(op_q)) |-> $stable(mul_lo_o));
  p_mul_lo_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(mul_lo_o));
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_r = 1'b0;
  logic [1:0]  op_r = 2'b00;
  logic [31:0] a_r = '0, b_r = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o, mul_lo_o;

  int checks = 0, failures = 0;

  // reference state
  bit          m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [31:0] m_hi = '0, m_lo = '0, m_ml = '0;
  logic [31:0] p_hi, p_lo;
  logic [1:0]  p_op;
  string       res_tag = "R9";
  string       seq_tag = "R2";

  always #2.5 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_r), .op_i(op_r),
    .a_i(a_r), .b_i(b_r), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o), .mul_lo_o(mul_lo_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic ref_calc(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] hi, output logic [31:0] lo, output string tag);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = $signed(a);
    sb = $signed(b);
    case (op)
      2'b00: begin p = 64'(sa * sb); hi = p[63:32]; lo = p[31:0]; tag = "R5"; end
      2'b01: begin p = 64'(a) * 64'(b); hi = p[63:32]; lo = p[31:0]; tag = "R4"; end
      2'b10: begin
        if (b == 0) begin hi = a; lo = a[31] ? 32'h1 : 32'hFFFF_FFFF; tag = "R8"; end
        else begin q = sa / sb; r = sa % sb; hi = r[31:0]; lo = q[31:0]; tag = "R7"; end
      end
      default: begin
        if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; tag = "R8"; end
        else begin hi = a % b; lo = a / b; tag = "R6"; end
      end
    endcase
  endtask

  // one clock: advance model at the edge, compare at the falling edge
  task automatic tick();
    string t;
    @(posedge clk);
    m_done = 0;
    if (start_r && !m_busy) begin
      m_busy = 1; m_cnt = 0; p_op = op_r;
      ref_calc(op_r, a_r, b_r, p_hi, p_lo, t);
      res_tag = t;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == 32) begin
        m_busy = 0; m_done = 1; m_hi = p_hi; m_lo = p_lo;
        if (!p_op[1]) m_ml = p_lo;
      end
    end
    @(negedge clk);
    chk(seq_tag, "busy", 32'(busy_o), 32'(m_busy));
    chk(seq_tag, "done", 32'(done_o), 32'(m_done));
    chk(m_done ? res_tag : "R9", "hi", hi_o, m_hi);
    chk(m_done ? res_tag : "R9", "lo", lo_o, m_lo);
    chk("R10", "mul_lo", mul_lo_o, m_ml);
  endtask

  task automatic run_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    op_r = op; a_r = a; b_r = b; start_r = 1'b1;
    tick();
    start_r = 1'b0;
    while (m_busy) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    // R1: reset values
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy_o), 0);
    chk("R1", "hi in reset", hi_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", 32'(done_o), 0);
    chk("R1", "lo after reset", lo_o, 0);
    chk("R1", "mul_lo after reset", mul_lo_o, 0);
    tick();

    // R4/R5 multiplies
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'b01, 32'd1000, 32'd3);
    run_op(2'b00, 32'hFFFF_FFFF, 32'd7);
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000);
    run_op(2'b00, 32'h8000_0000, 32'd1);
    run_op(2'b00, 32'hFFFF_FFF9, 32'd0);
    // R6/R7 divides; R10 mul_lo must survive them
    run_op(2'b11, 32'd100, 32'd7);
    run_op(2'b11, 32'hFFFF_FFFF, 32'd1);
    run_op(2'b11, 32'd5, 32'hFFFF_FFFF);
    run_op(2'b10, 32'hFFFF_FF9C, 32'd7);
    run_op(2'b10, 32'd100, 32'hFFFF_FFF9);
    run_op(2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    // R8 zero divisor
    run_op(2'b11, 32'h1234_5678, 32'd0);
    run_op(2'b10, 32'hFFFF_FF00, 32'd0);
    run_op(2'b10, 32'd42, 32'd0);

    // R3: stray starts mid-operation with other operands
    seq_tag = "R3";
    op_r = 2'b01; a_r = 32'd9; b_r = 32'd11; start_r = 1'b1;
    tick();
    start_r = 1'b0;
    repeat (5) tick();
    op_r = 2'b11; a_r = 32'd77; b_r = 32'd0; start_r = 1'b1;
    repeat (3) tick();
    start_r = 1'b0;
    while (m_busy) tick();
    tick();
    chk("R3", "no queued op", 32'(busy_o), 0);

    // R2: launch in the done cycle (back to back)
    seq_tag = "R2";
    op_r = 2'b00; a_r = 32'hFFFF_FFFE; b_r = 32'd3; start_r = 1'b1;
    tick();
    start_r = 1'b0;
    while (m_busy) tick();
    op_r = 2'b10; a_r = 32'd50; b_r = 32'd4; start_r = 1'b1;
    tick();
    start_r = 1'b0;
    while (m_busy) tick();
    repeat (3) tick();

    // mixed pseudo-random operations
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] x, y;
      lcg = lcg * 32'd1664525 + 32'd1013904223; x = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; y = lcg;
      if (i % 5 == 4) y = y >> (i % 29);
      run_op(2'(i), x, y);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule